// File: doc/BRIEF.md
# BCD to Excess-3 Digit Converter

This block turns one 4-bit binary-coded decimal digit into its Excess-3 form, the value of the digit plus three. It is purely combinational: a digit presented at the input shows up as a code at the output in the same cycle, with no clock and no state.

The conversion is built twice inside the block. One path is a two-level network of AND and OR terms taken from minimised equations, where the six unused input codes were treated as free. The other path adds the constant three with a ripple chain of full adders. Its first carry is tied low and its last carry is never formed. A parameter picks which path drives the output. The two results are compared on every valid digit, and any disagreement raises a mismatch flag. A separate flag marks input codes above nine. For those codes the output value is not defined.

Top module: `bcdx3_conv`

## Requirements
- R1: For every input digit from 0 to 9, code_o equals the digit plus 3 as a 4-bit binary value. Examples: 0 gives 4'b0011 and 9 gives 4'b1100.
- R2: invalid_o is 1 exactly when digit_i is 10 to 15 (4'b1010 to 4'b1111). For 0 to 9 it is 0.
- R3: mismatch_o is 0 for every digit from 0 to 9, because the gate path and the adder path agree on all of them.
- R4: mismatch_o is 0 for every digit from 10 to 15, because the comparison only counts when the digit is valid.
- R5: For a valid digit, bit 0 of code_o is the inverse of bit 0 of digit_i.
- R6: For a valid digit, bit 3 of code_o is 1 exactly for digits 5 to 9.
- R7: An instance that takes its output from the adder path gives the same code_o on every valid digit as an instance that takes it from the gate path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| digit_i | input | 4 | BCD digit to convert |
| code_o | output | 4 | Excess-3 code of the digit |
| invalid_o | output | 1 | High when the digit is above nine |
| mismatch_o | output | 1 | High when the two internal paths disagree on a valid digit |

## Verification
The bench builds two instances with the default width, offset and limit. One is set to the gate source and the other to the adder source. Between them, each path reaches code_o directly, so a fault in either path shows up at the output and not only through the mismatch flag. All sixteen input codes are swept first. Seeded random digits then revisit the range edges at 9 and 10 many times, and the two instances are compared on every valid digit.

// File: rtl/bcdx3_pkg.sv
package bcdx3_pkg;

   // Which internal path drives the converter output.
   typedef enum logic {
      SRC_GATE  = 1'b0,
      SRC_ADDER = 1'b1
   } src_e;

   // Width and offset the minimised gate equations are written for.
   localparam int GATE_W      = 4;
   localparam int GATE_OFFSET = 3;

endpackage

// File: rtl/bcdx3_gate_net.sv
// Two-level sum-of-products network for the digit-plus-three mapping.
// Codes above nine were left free when the terms were minimised.
module bcdx3_gate_net (
   input  logic [3:0] bcd_i,
   output logic [3:0] xs3_o
);
   logic a, b, c, d;

   always_comb begin
      a = bcd_i[3];
      b = bcd_i[2];
      c = bcd_i[1];
      d = bcd_i[0];
      xs3_o[3] = a | (b & c) | (b & d);
      xs3_o[2] = (~b & c) | (~b & d) | (b & ~c & ~d);
      xs3_o[1] = (c & d) | (~c & ~d);
      xs3_o[0] = ~d;
   end
endmodule

// File: rtl/bcdx3_ripple_add.sv
// Ripple-carry adder of a value and a fixed constant.
// The chain starts with a zero carry, and the carry out of the top stage
// is never formed.
module bcdx3_ripple_add #(
   parameter int W     = 4,
   parameter int ADDEND = 3
) (
   input  logic [W-1:0] a_i,
   output logic [W-1:0] sum_o
);
   localparam logic [W-1:0] K = ADDEND[W-1:0];

   logic [W-1:0] carry;   // carry into each stage
   assign carry[0] = 1'b0;

   for (genvar i = 0; i < W; i++) begin : g_stage
      assign sum_o[i] = a_i[i] ^ K[i] ^ carry[i];
      if (i < W - 1) begin : g_carry
         assign carry[i+1] = (a_i[i] & K[i]) | ((a_i[i] ^ K[i]) & carry[i]);
      end
   end
endmodule

// File: rtl/bcdx3_conv.sv
module bcdx3_conv #(
   parameter int               DIGIT_W   = 4,
   parameter int               MAX_DIGIT = 9,
   parameter int               OFFSET    = 3,
   parameter bcdx3_pkg::src_e  OUT_SRC   = bcdx3_pkg::SRC_GATE
) (
   input  logic [DIGIT_W-1:0] digit_i,
   output logic [DIGIT_W-1:0] code_o,
   output logic               invalid_o,
   output logic               mismatch_o
);
   localparam logic [DIGIT_W-1:0] LIMIT = MAX_DIGIT[DIGIT_W-1:0];

   // Elaboration-time checks on the parameters.
   if (DIGIT_W != bcdx3_pkg::GATE_W) begin : g_bad_width
      $error("bcdx3_conv: DIGIT_W must be %0d", bcdx3_pkg::GATE_W);
   end
   if (OFFSET != bcdx3_pkg::GATE_OFFSET) begin : g_bad_offset
      $error("bcdx3_conv: OFFSET must be %0d", bcdx3_pkg::GATE_OFFSET);
   end
   if (MAX_DIGIT < 1 || MAX_DIGIT >= (1 << DIGIT_W)) begin : g_bad_limit
      $error("bcdx3_conv: MAX_DIGIT out of range");
   end

   logic [DIGIT_W-1:0] gate_code;
   logic [DIGIT_W-1:0] add_code;

   bcdx3_gate_net i_gate (
      .bcd_i (digit_i),
      .xs3_o (gate_code)
   );

   bcdx3_ripple_add #(
      .W      (DIGIT_W),
      .ADDEND (OFFSET)
   ) i_add (
      .a_i   (digit_i),
      .sum_o (add_code)
   );

   if (OUT_SRC == bcdx3_pkg::SRC_ADDER) begin : g_out_adder
      assign code_o = add_code;
   end else begin : g_out_gate
      assign code_o = gate_code;
   end

   assign invalid_o  = (digit_i > LIMIT);
   assign mismatch_o = ~invalid_o & (gate_code != add_code);
endmodule

// File: rtl/bcdx3_conv_chk.sv
module bcdx3_conv_chk #(
   parameter int DIGIT_W   = 4,
   parameter int MAX_DIGIT = 9,
   parameter int OFFSET    = 3
) (
   input logic [DIGIT_W-1:0] digit_i,
   input logic [DIGIT_W-1:0] code_o,
   input logic               invalid_o,
   input logic               mismatch_o
);
   always_comb begin
      if (digit_i <= DIGIT_W'(MAX_DIGIT)) begin
         assert_sum_R1:   assert (code_o == DIGIT_W'(digit_i + DIGIT_W'(OFFSET)));
         assert_agree_R3: assert (!mismatch_o);
         assert_lsb_R5:   assert (code_o[0] == ~digit_i[0]);
      end else begin
         assert_quiet_R4: assert (!mismatch_o);
      end
      assert_range_R2: assert (invalid_o == (int'(digit_i) > MAX_DIGIT));
   end
endmodule

bind bcdx3_conv bcdx3_conv_chk #(
   .DIGIT_W   (DIGIT_W),
   .MAX_DIGIT (MAX_DIGIT),
   .OFFSET    (OFFSET)
) i_chk (
   .digit_i    (digit_i),
   .code_o     (code_o),
   .invalid_o  (invalid_o),
   .mismatch_o (mismatch_o)
);

// File: tb/test_bcdx3_conv.sv
module test_bcdx3_conv;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] digit;
   logic [3:0] code_g, code_a;
   logic       inv_g, inv_a, mis_g, mis_a;
   int         n_chk  = 0;
   int         n_fail = 0;
   bit         done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   bcdx3_conv #(.OUT_SRC(bcdx3_pkg::SRC_GATE)) i_bcdx3_conv (
      .digit_i(digit), .code_o(code_g), .invalid_o(inv_g), .mismatch_o(mis_g));

   bcdx3_conv #(.OUT_SRC(bcdx3_pkg::SRC_ADDER)) i_bcdx3_conv_adder (
      .digit_i(digit), .code_o(code_a), .invalid_o(inv_a), .mismatch_o(mis_a));

   function automatic logic [3:0] exp_code(input logic [3:0] d);
      return 4'(d + 4'd3);
   endfunction

   function automatic logic exp_invalid(input logic [3:0] d);
      return d > 4'd9;
   endfunction

   task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s digit=%0d actual=%b expected=%b", req, digit, act, exp);
      end
   endtask

   task automatic apply(input logic [3:0] d);
      @(posedge clk);
      digit = d;
      @(negedge clk);
      check("R2", {3'b0, inv_g}, {3'b0, exp_invalid(d)});
      check("R2", {3'b0, inv_a}, {3'b0, exp_invalid(d)});
      if (!exp_invalid(d)) begin
         check("R1", code_g, exp_code(d));
         check("R3", {3'b0, mis_g}, 4'd0);
         check("R3", {3'b0, mis_a}, 4'd0);
         check("R5", {3'b0, code_g[0]}, {3'b0, ~d[0]});
         check("R6", {3'b0, code_g[3]}, {3'b0, (d >= 4'd5)});
         check("R7", code_a, code_g);
      end else begin
         check("R4", {3'b0, mis_g}, 4'd0);
         check("R4", {3'b0, mis_a}, 4'd0);
      end
   endtask

   initial begin
      digit = 4'd0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      // Reset state: digit zero at the input.
      check("R1", code_g, 4'b0011);
      check("R2", {3'b0, inv_g}, 4'd0);
      // Directed sweep of every input code.
      for (int i = 0; i < 16; i++) apply(4'(i));
      // Range edges.
      apply(4'd9);
      apply(4'd10);
      apply(4'd15);
      apply(4'd0);
      // Seeded random digits.
      void'($urandom(32'd2718));
      for (int k = 0; k < 300; k++) apply(4'($urandom % 16));
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (50000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule